// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block produces every timing pulse a three-row linear CCD sensor needs, and it runs from a single system clock. For each line it first raises the charge transfer gate once. It then clocks the analog shift registers for a fixed number of pixel periods. In every pixel period it emits one reset-gate pulse and one clamp pulse. Reset and clamp keep running while the transfer gate is high, so the sensor output stage sees the same pulse pattern at all times.

Pulse widths and the gaps around the transfer gate are counted in system-clock cycles and are fixed in time. They are not tied to the pixel count. Each readout pixel is labelled with its region: leading dummy, optical black, valid image or trailing invalid. The block also gives its index and a sampling strobe, so a downstream converter knows which samples to keep. All durations are parameters. At elaboration, each one is checked against the sensor's minimum timing at the stated clock period.

Top module: `ccd_clkgen`

## Requirements
- R1: After reset, and while no line is running, every output is low (the index is zero). Asserting reset in the middle of a line forces all outputs low.
- R2: The two shift clocks are never high together while a line runs. They change only at a pixel-period boundary during readout, once per readout period. Both are low when idle. The first clock is high and the second is low from line start until readout begins.
- R3: At line start the first shift clock goes high. The transfer gate rises TG_LEAD cycles later and stays high for exactly TG_W cycles. Readout starts at the first pixel boundary that is at least TG_HOLD cycles after the gate falls. That is also the first shift-clock change after the gate falls.
- R4: While a line runs, including the whole transfer-gate interval, reset is high in pixel-period cycles RS_OFF to RS_OFF+RS_W-1. Clamp is high in cycles CP_OFF to CP_OFF+CP_W-1. The two are never high together.
- R5: Readout pixels carry indices 0 to N-1 in order. The region code is 0 for the first N_DUMMY pixels, 1 for the next N_BLACK, 2 for the next N_VALID and 3 for the last N_TRAIL. Outside readout the code and the index are 0.
- R6: Region-valid is high for every readout cycle and only then. The pixel strobe pulses for one cycle at pixel-period cycle SMP_OFF of each readout period.
- R7: If enable is high at the last cycle of a line, the next line starts in the following cycle. If enable drops during a line, that line still finishes, and then the block goes idle.
- R8: A one-cycle enable pulse while idle produces exactly one complete line. Outputs respond one cycle after the edge that samples enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | Run enable, sampled at line boundaries |
| tg_o | output | 1 | Transfer gate pulse |
| phi1_o | output | 1 | Shift-register clock, first phase |
| phi2_o | output | 1 | Shift-register clock, complementary phase |
| rs_o | output | 1 | Reset gate pulse |
| cp_o | output | 1 | Clamp pulse |
| pix_stb_o | output | 1 | Per-pixel sampling strobe |
| pix_region_o | output | 2 | Region code of the current readout pixel |
| region_vld_o | output | 1 | High during readout periods |
| pix_idx_o | output | PIX_W | Index of the current readout pixel |

## Verification
The line sequencer holds a state and a pixel counter. If that state is wrong, the transfer-gate edges, the shift-clock pattern or the region code shift away from the reference in the same cycle, often by a whole pixel period. The bench therefore compares every output against a line-time model on every clock. A fault in the pixel-period counter shows up at once as a reset or clamp window out of place. A sequencing fault shows up in the lengths of the transfer gate and the hold gap, and also as a wrong per-region strobe count over a line.

// File: rtl/ccd_clkgen_pkg.sv
package ccd_clkgen_pkg;

   typedef enum logic [2:0] {
      LS_IDLE  = 3'd0,
      LS_LEAD  = 3'd1,
      LS_TGATE = 3'd2,
      LS_HOLD  = 3'd3,
      LS_READ  = 3'd4
   } line_st_t;

   typedef enum logic [1:0] {
      RG_DUMMY = 2'd0,
      RG_BLACK = 2'd1,
      RG_VALID = 2'd2,
      RG_TRAIL = 2'd3
   } region_t;

   typedef struct packed {
      logic    tg;
      logic    phi1;
      logic    phi2;
      logic    rs;
      logic    cp;
      logic    stb;
      logic    rvld;
      region_t region;
   } drive_t;

endpackage

// File: rtl/ccd_pix_phase.sv
module ccd_pix_phase #(
   parameter int PIX_CYC = 100,
   parameter int RS_OFF  = 8,
   parameter int RS_W    = 15,
   parameter int CP_OFF  = 25,
   parameter int CP_W    = 2,
   parameter int SMP_OFF = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic pcnt_last,
   output logic rs_win,
   output logic cp_win,
   output logic smp_hit
);

   localparam int PW     = $clog2(PIX_CYC);
   localparam int RS_END = RS_OFF + RS_W;
   localparam int CP_END = CP_OFF + CP_W;
   localparam logic [PW-1:0] PC_LAST = PW'(PIX_CYC - 1);

   logic [PW-1:0] pcnt;
   int            pos;

   assign pos       = int'(pcnt);
   assign pcnt_last = run && (pcnt == PC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt <= '0;
      else if (!run || pcnt_last)
         pcnt <= '0;
      else
         pcnt <= pcnt + 1'b1;
   end

   always_comb begin
      rs_win  = run && (pos >= RS_OFF) && (pos < RS_END);
      cp_win  = run && (pos >= CP_OFF) && (pos < CP_END);
      smp_hit = run && (pos == SMP_OFF);
   end

   AST_PCNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pcnt == '0)) else $error("pixel counter not cleared");   // R4

endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
   import ccd_clkgen_pkg::*;
#(
   parameter int NPIX    = 10669,
   parameter int PIX_W   = 14,
   parameter int TG_LEAD = 5,
   parameter int TG_W    = 1000,
   parameter int TG_HOLD = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             pcnt_last,
   output line_st_t         st_o,
   output logic [PIX_W-1:0] pix_o,
   output logic             phi_o
);

   localparam int TMAX0 = (TG_LEAD > TG_W) ? TG_LEAD : TG_W;
   localparam int TMAX  = (TMAX0 > TG_HOLD) ? TMAX0 : TG_HOLD;
   localparam int TW    = $clog2(TMAX + 1);
   localparam logic [TW-1:0]    LEAD_LAST = TW'(TG_LEAD - 1);
   localparam logic [TW-1:0]    GATE_LAST = TW'(TG_W - 1);
   localparam logic [TW-1:0]    HOLD_LAST = TW'(TG_HOLD - 1);
   localparam logic [PIX_W-1:0] PIX_LAST  = PIX_W'(NPIX - 1);

   line_st_t         st;
   logic [TW-1:0]    cyc;
   logic [PIX_W-1:0] pix;
   logic             phi;
   logic             hold_done;
   logic             line_last;

   assign hold_done = (cyc >= HOLD_LAST);
   assign line_last = pcnt_last && (pix == PIX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= LS_IDLE;
         cyc <= '0;
         pix <= '0;
         phi <= 1'b0;
      end else begin
         unique case (st)
            LS_IDLE: begin
               if (en_i) begin
                  st  <= LS_LEAD;
                  cyc <= '0;
                  pix <= '0;
                  phi <= 1'b1;
               end
            end
            LS_LEAD: begin
               if (cyc == LEAD_LAST) begin
                  st  <= LS_TGATE;
                  cyc <= '0;
               end else begin
                  cyc <= cyc + 1'b1;
               end
            end
            LS_TGATE: begin
               if (cyc == GATE_LAST) begin
                  st  <= LS_HOLD;
                  cyc <= '0;
               end else begin
                  cyc <= cyc + 1'b1;
               end
            end
            LS_HOLD: begin
               if (hold_done && pcnt_last) begin
                  st  <= LS_READ;
                  pix <= '0;
                  phi <= ~phi;
               end else if (!hold_done) begin
                  cyc <= cyc + 1'b1;
               end
            end
            LS_READ: begin
               if (line_last) begin
                  pix <= '0;
                  if (en_i) begin
                     st  <= LS_LEAD;
                     cyc <= '0;
                     phi <= 1'b1;
                  end else begin
                     st  <= LS_IDLE;
                     phi <= 1'b0;
                  end
               end else if (pcnt_last) begin
                  pix <= pix + 1'b1;
                  phi <= ~phi;
               end
            end
            default: st <= LS_IDLE;
         endcase
      end
   end

   assign st_o  = st;
   assign pix_o = pix;
   assign phi_o = phi;

   AST_LINE_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LS_READ && !line_last) |=> (st == LS_READ)) else $error("line aborted");   // R7
   AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LS_READ) |-> (pix <= PIX_LAST)) else $error("pixel index overrun");   // R5
   AST_GATE_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LS_TGATE) |-> ($past(st) == LS_LEAD || $past(st) == LS_TGATE)) else $error("gate skipped lead");   // R3

endmodule

// File: rtl/ccd_drive_out.sv
module ccd_drive_out
   import ccd_clkgen_pkg::*;
#(
   parameter int N_DUMMY = 18,
   parameter int N_BLACK = 49,
   parameter int N_VALID = 10600,
   parameter int PIX_W   = 14,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  line_st_t         st,
   input  logic [PIX_W-1:0] pix,
   input  logic             phi,
   input  logic             rs_win,
   input  logic             cp_win,
   input  logic             smp_hit,
   output drive_t           drv_o,
   output logic [PIX_W-1:0] pix_o
);

   localparam int B_BLACK = N_DUMMY;
   localparam int B_VALID = N_DUMMY + N_BLACK;
   localparam int B_TRAIL = N_DUMMY + N_BLACK + N_VALID;

   drive_t           nxt;
   logic [PIX_W-1:0] nxt_pix;
   logic             active;
   logic             rd;
   region_t          reg_code;
   int               pv;

   assign pv     = int'(pix);
   assign active = (st != LS_IDLE);
   assign rd     = (st == LS_READ);

   always_comb begin
      if (pv < B_BLACK)      reg_code = RG_DUMMY;
      else if (pv < B_VALID) reg_code = RG_BLACK;
      else if (pv < B_TRAIL) reg_code = RG_VALID;
      else                   reg_code = RG_TRAIL;
   end

   always_comb begin
      nxt.tg     = (st == LS_TGATE);
      nxt.phi1   = active & phi;
      nxt.phi2   = active & ~phi;
      nxt.rs     = rs_win;
      nxt.cp     = cp_win;
      nxt.stb    = rd & smp_hit;
      nxt.rvld   = rd;
      nxt.region = rd ? reg_code : RG_DUMMY;
      nxt_pix    = rd ? pix : '0;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               drv_o <= '0;
               pix_o <= '0;
            end else begin
               drv_o <= nxt;
               pix_o <= nxt_pix;
            end
         end
      end else begin : g_comb
         assign drv_o = nxt;
         assign pix_o = nxt_pix;
      end
   endgenerate

endmodule

// File: rtl/ccd_clkgen.sv
module ccd_clkgen
   import ccd_clkgen_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 10,
   parameter int PIX_CYC       = 100,
   parameter int N_DUMMY       = 18,
   parameter int N_BLACK       = 49,
   parameter int N_VALID       = 10600,
   parameter int N_TRAIL       = 2,
   parameter int TG_LEAD       = 5,
   parameter int TG_W          = 1000,
   parameter int TG_HOLD       = 100,
   parameter int RS_OFF        = 8,
   parameter int RS_W          = 15,
   parameter int CP_OFF        = 25,
   parameter int CP_W          = 2,
   parameter int SMP_OFF       = 60,
   parameter bit REG_OUT       = 1'b1,
   localparam int NPIX         = N_DUMMY + N_BLACK + N_VALID + N_TRAIL,
   localparam int PIX_W        = $clog2(NPIX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_en,
   output logic             tg_o,
   output logic             phi1_o,
   output logic             phi2_o,
   output logic             rs_o,
   output logic             cp_o,
   output logic             pix_stb_o,
   output logic [1:0]       pix_region_o,
   output logic             region_vld_o,
   output logic [PIX_W-1:0] pix_idx_o
);

   localparam int RUN_W  = $clog2(TG_W + 2);
   localparam int GAP_W  = $clog2(TG_HOLD + 2);

   // elaboration-time timing limits
   generate
      if (PIX_CYC * CLK_PERIOD_NS < 500) begin : g_err_rate
         $error("pixel rate above 2 MHz");
      end
      if (TG_W * CLK_PERIOD_NS < 3000) begin : g_err_tgw
         $error("transfer gate shorter than 3000 ns");
      end
      if (TG_HOLD * CLK_PERIOD_NS < 900) begin : g_err_hold
         $error("post-gate hold shorter than 900 ns");
      end
      if (TG_LEAD < 1) begin : g_err_lead
         $error("gate lead must be at least one cycle");
      end
      if (RS_W * CLK_PERIOD_NS < 70 || RS_OFF * CLK_PERIOD_NS < 30) begin : g_err_rs
         $error("reset pulse too short or too close to shift edge");
      end
      if (CP_W * CLK_PERIOD_NS < 10 || (CP_OFF - RS_OFF - RS_W) * CLK_PERIOD_NS < 5) begin : g_err_cp
         $error("clamp pulse too short or too close to reset");
      end
      if (CP_OFF + CP_W > PIX_CYC || SMP_OFF >= PIX_CYC) begin : g_err_fit
         $error("pulses do not fit in one pixel period");
      end
      if (NPIX < 2) begin : g_err_npix
         $error("line needs at least two pixels");
      end
   endgenerate

   line_st_t         st;
   logic [PIX_W-1:0] pix;
   logic             phi;
   logic             pcnt_last;
   logic             rs_win;
   logic             cp_win;
   logic             smp_hit;
   drive_t           drv;

   ccd_pix_phase #(
      .PIX_CYC (PIX_CYC),
      .RS_OFF  (RS_OFF),
      .RS_W    (RS_W),
      .CP_OFF  (CP_OFF),
      .CP_W    (CP_W),
      .SMP_OFF (SMP_OFF)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (st != LS_IDLE),
      .pcnt_last (pcnt_last),
      .rs_win    (rs_win),
      .cp_win    (cp_win),
      .smp_hit   (smp_hit)
   );

   ccd_line_seq #(
      .NPIX    (NPIX),
      .PIX_W   (PIX_W),
      .TG_LEAD (TG_LEAD),
      .TG_W    (TG_W),
      .TG_HOLD (TG_HOLD)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (line_en),
      .pcnt_last (pcnt_last),
      .st_o      (st),
      .pix_o     (pix),
      .phi_o     (phi)
   );

   ccd_drive_out #(
      .N_DUMMY (N_DUMMY),
      .N_BLACK (N_BLACK),
      .N_VALID (N_VALID),
      .PIX_W   (PIX_W),
      .REG_OUT (REG_OUT)
   ) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .st      (st),
      .pix     (pix),
      .phi     (phi),
      .rs_win  (rs_win),
      .cp_win  (cp_win),
      .smp_hit (smp_hit),
      .drv_o   (drv),
      .pix_o   (pix_idx_o)
   );

   assign tg_o         = drv.tg;
   assign phi1_o       = drv.phi1;
   assign phi2_o       = drv.phi2;
   assign rs_o         = drv.rs;
   assign cp_o         = drv.cp;
   assign pix_stb_o    = drv.stb;
   assign region_vld_o = drv.rvld;
   assign pix_region_o = drv.region;

   // counters for window checks on the drive outputs
   logic [RUN_W-1:0] tg_run;
   logic [GAP_W-1:0] since_tg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tg_run   <= '0;
         since_tg <= GAP_W'(TG_HOLD);
      end else begin
         if (tg_o)
            tg_run <= (int'(tg_run) > TG_W) ? tg_run : tg_run + 1'b1;
         else
            tg_run <= '0;
         if (tg_o)
            since_tg <= '0;
         else if (int'(since_tg) < TG_HOLD)
            since_tg <= since_tg + 1'b1;
      end
   end

   AST_TG_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tg_o) |-> (int'(tg_run) == TG_W)) else $error("gate width wrong");   // R3
   AST_HOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(phi1_o) && !tg_o) |-> (int'(since_tg) >= TG_HOLD)) else $error("shift edge too soon after gate");   // R3
   AST_PHI_STEADY_TG: assert property (@(posedge clk) disable iff (!rst_n)
      tg_o |-> ($stable(phi1_o) && phi1_o && !phi2_o)) else $error("shift clock moved during gate");   // R2
   AST_PHI_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(phi1_o && phi2_o)) else $error("shift clocks overlap");   // R2
   AST_RS_CP_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(rs_o && cp_o)) else $error("reset and clamp overlap");   // R4
   AST_STB_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      pix_stb_o |-> region_vld_o) else $error("strobe outside readout");   // R6

endmodule

// File: tb/ccd_clkgen_tb.sv
module ccd_clkgen_tb;

   localparam int P    = 50;
   localparam int ND   = 4;
   localparam int NB   = 3;
   localparam int NV   = 8;
   localparam int NT   = 2;
   localparam int L    = 5;
   localparam int TGW  = 300;
   localparam int HOLD = 90;
   localparam int RSO  = 3;
   localparam int RSW  = 7;
   localparam int CPO  = 11;
   localparam int CPW  = 1;
   localparam int SMP  = 30;
   localparam int N    = ND + NB + NV + NT;
   localparam int PW   = $clog2(N);
   localparam int RD   = ((L + TGW + HOLD + P - 1) / P) * P;
   localparam int LINE = RD + N * P;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_en = 1'b0;
   logic          tg_o, phi1_o, phi2_o, rs_o, cp_o, pix_stb_o, region_vld_o;
   logic [1:0]    pix_region_o;
   logic [PW-1:0] pix_idx_o;

   always #5 clk = ~clk;

   ccd_clkgen #(
      .CLK_PERIOD_NS (10),
      .PIX_CYC (P), .N_DUMMY (ND), .N_BLACK (NB), .N_VALID (NV), .N_TRAIL (NT),
      .TG_LEAD (L), .TG_W (TGW), .TG_HOLD (HOLD),
      .RS_OFF (RSO), .RS_W (RSW), .CP_OFF (CPO), .CP_W (CPW), .SMP_OFF (SMP),
      .REG_OUT (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .line_en (line_en),
      .tg_o (tg_o), .phi1_o (phi1_o), .phi2_o (phi2_o), .rs_o (rs_o), .cp_o (cp_o),
      .pix_stb_o (pix_stb_o), .pix_region_o (pix_region_o),
      .region_vld_o (region_vld_o), .pix_idx_o (pix_idx_o)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   // reference model: time since line start
   bit m_act;
   int m_k;
   bit e_act, e_tg, e_phi1, e_phi2, e_rs, e_cp, e_stb, e_rvld;
   int e_reg, e_pix;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 0; m_k = 0;
         e_act = 0; e_tg = 0; e_phi1 = 0; e_phi2 = 0; e_rs = 0; e_cp = 0;
         e_stb = 0; e_rvld = 0; e_reg = 0; e_pix = 0;
      end else begin
         e_act = m_act;
         if (!m_act) begin
            e_tg = 0; e_phi1 = 0; e_phi2 = 0; e_rs = 0; e_cp = 0;
            e_stb = 0; e_rvld = 0; e_reg = 0; e_pix = 0;
         end else begin
            int pc, j;
            pc = m_k % P;
            j  = (m_k >= RD) ? (m_k - RD) / P : 0;
            e_tg   = (m_k >= L) && (m_k < L + TGW);
            e_phi1 = (m_k < RD) ? 1'b1 : (j % 2 == 1);
            e_phi2 = !e_phi1;
            e_rs   = (pc >= RSO) && (pc < RSO + RSW);
            e_cp   = (pc >= CPO) && (pc < CPO + CPW);
            e_rvld = (m_k >= RD);
            e_stb  = e_rvld && (pc == SMP);
            e_pix  = e_rvld ? j : 0;
            if (!e_rvld)               e_reg = 0;
            else if (j < ND)           e_reg = 0;
            else if (j < ND + NB)      e_reg = 1;
            else if (j < ND + NB + NV) e_reg = 2;
            else                       e_reg = 3;
         end
         if (!m_act) begin
            if (line_en) begin m_act = 1; m_k = 0; end
         end else if (m_k == LINE - 1) begin
            if (line_en) m_k = 0;
            else m_act = 0;
         end else begin
            m_k++;
         end
      end
   end

   // per-cycle comparison and monitors
   int  tg_rises, stb_cnt, tg_len, tg_run, gap, last_gap;
   int  reg_cnt [4];
   bit  tg_prev, phi_prev, gap_arm;

   always @(negedge clk) begin
      string a, b, c, d, e;
      a = e_act ? "R3" : "R1";
      b = e_act ? "R2" : "R1";
      c = e_act ? "R4" : "R1";
      d = e_act ? "R5" : "R1";
      e = e_act ? "R6" : "R1";
      chk(a, "tg", int'(tg_o), int'(e_tg));
      chk(b, "phi1", int'(phi1_o), int'(e_phi1));
      chk(b, "phi2", int'(phi2_o), int'(e_phi2));
      chk(c, "rs", int'(rs_o), int'(e_rs));
      chk(c, "cp", int'(cp_o), int'(e_cp));
      chk(d, "region", int'(pix_region_o), e_reg);
      chk(d, "pix_idx", int'(pix_idx_o), e_pix);
      chk(e, "strobe", int'(pix_stb_o), int'(e_stb));
      chk(e, "region_vld", int'(region_vld_o), int'(e_rvld));
      if (tg_o && !tg_prev) tg_rises++;
      if (tg_o) tg_run++;
      if (!tg_o && tg_prev) begin tg_len = tg_run; tg_run = 0; gap = 0; gap_arm = 1; end
      else if (gap_arm) begin
         gap++;
         if (phi1_o != phi_prev) begin last_gap = gap; gap_arm = 0; end
      end
      if (pix_stb_o) begin stb_cnt++; reg_cnt[pix_region_o]++; end
      tg_prev  = tg_o;
      phi_prev = phi1_o;
   end

   task automatic clr_mon();
      tg_rises = 0; stb_cnt = 0;
      for (int i = 0; i < 4; i++) reg_cnt[i] = 0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual hung, expected completion");
      finish_run();
   end

   initial begin
      clr_mon();
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R1", "idle phi2 low", int'(phi2_o), 0);
      chk("R1", "idle tg low", int'(tg_o), 0);
      chk("R1", "idle no strobes", stb_cnt, 0);

      // continuous lines, then enable dropped mid-readout
      @(posedge clk); #1 clr_mon(); line_en = 1'b1;
      repeat (3 * LINE + 600) @(posedge clk);
      #1 line_en = 1'b0;
      repeat (1000) @(posedge clk);
      @(negedge clk);
      chk("R7", "gate pulses over four lines", tg_rises, 4);
      chk("R7", "strobes over four lines", stb_cnt, 4 * N);
      chk("R7", "idle after finished line", int'(region_vld_o), 0);
      chk("R3", "gate width", tg_len, TGW);
      chk("R3", "gate fall to first shift edge", last_gap, RD - L - TGW);

      // single-cycle enable pulse
      @(posedge clk); #1 clr_mon(); line_en = 1'b1;
      @(posedge clk); #1 line_en = 1'b0;
      repeat (LINE + 150) @(posedge clk);
      @(negedge clk);
      chk("R8", "gate pulses from one pulse", tg_rises, 1);
      chk("R8", "strobes from one pulse", stb_cnt, N);
      chk("R5", "dummy count", reg_cnt[0], ND);
      chk("R5", "black count", reg_cnt[1], NB);
      chk("R5", "valid count", reg_cnt[2], NV);
      chk("R5", "trailing count", reg_cnt[3], NT);

      // reset in the middle of a line
      @(posedge clk); #1 line_en = 1'b1;
      repeat (700) @(posedge clk);
      #1 rst_n = 1'b0; line_en = 1'b0;
      @(negedge clk);
      chk("R1", "reset clears phi1", int'(phi1_o), 0);
      chk("R1", "reset clears region_vld", int'(region_vld_o), 0);
      chk("R1", "reset clears pix_idx", int'(pix_idx_o), 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (100) @(posedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule